// File: doc/BRIEF.md
# Thermal Watchdog Alarm Controller

This block turns a stream of temperature conversion results into a single over-temperature alarm pin. Every time the sensor front end finishes a conversion, it presents a signed temperature word with a one-cycle strobe. The block compares that word against two programmable limits, a hot limit and a lower release limit. A programmable fault queue then filters the result: the alarm changes state only after a run of consecutive conversions that all meet the trip condition.

The block has two alarm modes. In comparator mode the alarm follows temperature with hysteresis. It raises after a run of readings above the hot limit and drops after a run of readings below the release limit. In interrupt mode the alarm latches and is released by any host register read. The event being watched alternates between crossing above the hot limit and falling below the release limit. A shutdown control freezes the alarm and the fault count, so all conversions and reads are ignored until shutdown is lifted. The pin polarity can be selected.

Temperatures and limits are signed two's-complement numbers in half-degree steps. The package provides power-up limit constants of 80 °C and 75 °C (raw values 160 and 150). The hot limit is expected to exceed the release limit.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After synchronous reset the alarm is inactive, so with `pol_high`=0 the pin `alarm_pin` reads 1.
- R2: In comparator mode (`irq_mode`=0) with the alarm inactive, a conversion trips only when temperature is strictly greater than `lim_hot`. The alarm becomes active in the cycle after the conversion that completes the required run.
- R3: In comparator mode with the alarm active, a conversion trips only when temperature is strictly less than `lim_rel`. A reading equal to `lim_rel` does not trip. The alarm becomes inactive after the required run.
- R4: In comparator mode, `reg_rd` has no effect on the alarm.
- R5: The fault-queue code `fq_sel` sets the run length: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 6 consecutive tripping conversions.
- R6: A counted conversion that does not trip restarts the run from zero.
- R7: In interrupt mode (`irq_mode`=1), a completed run latches the alarm active. It stays active until a cycle with `reg_rd`=1 and is inactive from the next cycle.
- R8: In interrupt mode the watched event alternates, starting with temperature above `lim_hot` after reset. Each latch switches the watch to the other event: temperature below `lim_rel`, then above `lim_hot` again.
- R9: In interrupt mode, conversions that arrive while the alarm is latched are not counted, including a conversion in the same cycle as the clearing read. Counting restarts from zero after the read.
- R10: While `shutdown`=1, conversions and reads are ignored, the alarm holds and the fault count holds. Normal operation resumes when `shutdown` returns to 0.
- R11: `alarm_pin` equals the alarm state when `pol_high`=1 and its inverse when `pol_high`=0, and it follows a change of `pol_high` at once.
- R12: Comparisons are signed, so negative limits and temperatures order correctly (for example, -3 is above a limit of -4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is valid |
| temp_in | input | TW | Signed temperature, half-degree units |
| lim_hot | input | TW | Signed over-temperature limit |
| lim_rel | input | TW | Signed release (hysteresis) limit |
| fq_sel | input | 2 | Fault-queue code: 1, 2, 4 or 6 consecutive faults |
| irq_mode | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| shutdown | input | 1 | 1 freezes conversions, reads and alarm |
| pol_high | input | 1 | 1 = alarm pin active high, 0 = active low |
| reg_rd | input | 1 | One-cycle strobe: host read of any register |
| alarm_pin | output | 1 | Alarm output after polarity |

## Verification
The bench targets readings exactly equal to either limit. A design that used non-strict comparisons would trip one reading early. The nonlinear 6-fault code is exercised by a run of five and then a sixth reading; a linear decode would switch at four or seven. A non-tripping reading placed in the middle of a run catches a counter that holds instead of restarting. In interrupt mode the bench sends a conversion while the alarm is latched, reads during shutdown, and waits for the second event of the alternation. A design that counted during the latch, cleared during shutdown, or kept watching the hot limit would change the pin on the wrong reading.

// File: rtl/thermwd_pkg.sv
package thermwd_pkg;

    localparam int TEMP_W = 9;
    localparam int FQ_MAX = 6;
    localparam int CNT_W  = $clog2(FQ_MAX + 1);

    localparam logic signed [TEMP_W-1:0] DEF_LIM_HOT = 9'sd160;
    localparam logic signed [TEMP_W-1:0] DEF_LIM_REL = 9'sd150;

    typedef enum logic [1:0] {
        FQ_RUN1 = 2'b00,
        FQ_RUN2 = 2'b01,
        FQ_RUN4 = 2'b10,
        FQ_RUN6 = 2'b11
    } fq_code_e;

    typedef enum logic {
        MODE_CMP = 1'b0,
        MODE_IRQ = 1'b1
    } alarm_mode_e;

    typedef struct packed {
        logic step;
        logic trip;
    } conv_eval_t;

    function automatic logic [CNT_W-1:0] fq_run_len(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        case (fq_code_e'(code))
            FQ_RUN1: n = CNT_W'(1);
            FQ_RUN2: n = CNT_W'(2);
            FQ_RUN4: n = CNT_W'(4);
            default: n = CNT_W'(FQ_MAX);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/thermwd_trip_detect.sv
module thermwd_trip_detect #(
    parameter int TW = thermwd_pkg::TEMP_W
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim_hot,
    input  logic [TW-1:0] lim_rel,
    input  logic          seek_hot,
    output logic          trip
);
    logic above_hot;
    logic below_rel;

    always_comb begin
        above_hot = $signed(temp) > $signed(lim_hot);
        below_rel = $signed(temp) < $signed(lim_rel);
        trip      = seek_hot ? above_hot : below_rel;
    end
endmodule

// File: rtl/thermwd_fault_queue.sv
module thermwd_fault_queue
    import thermwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  conv_eval_t ev,
    input  logic       hold,
    input  logic [1:0] fq_sel,
    output logic       fire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;
    logic             run_done;

    always_comb begin
        need     = fq_run_len(fq_sel);
        cnt_inc  = cnt_q + CNT_W'(1);
        run_done = cnt_inc >= need;
        fire     = ev.step && !hold && ev.trip && run_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (ev.step) begin
            if (!ev.trip || run_done) cnt_q <= '0;
            else                      cnt_q <= cnt_inc;
        end
    end

    a_r6_miss_restarts: assert property (@(posedge clk) disable iff (rst)
        (ev.step && !ev.trip) |=> (cnt_q == '0));

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(FQ_MAX));

    a_r10_count_holds_idle: assert property (@(posedge clk) disable iff (rst)
        (!ev.step && !hold) |=> $stable(cnt_q));
endmodule

// File: rtl/thermwd_alarm_state.sv
module thermwd_alarm_state
    import thermwd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode,
    input  logic fire,
    input  logic rd,
    input  logic freeze,
    output logic alarm,
    output logic seek_hot,
    output logic hold_queue
);
    logic cmp_act_q;
    logic irq_act_q;
    logic irq_seek_hot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act_q      <= 1'b0;
            irq_act_q      <= 1'b0;
            irq_seek_hot_q <= 1'b1;
        end else if (!freeze) begin
            if (alarm_mode_e'(mode) == MODE_CMP) begin
                if (fire) cmp_act_q <= !cmp_act_q;
            end else begin
                if (fire) begin
                    irq_act_q      <= 1'b1;
                    irq_seek_hot_q <= !irq_seek_hot_q;
                end else if (rd) begin
                    irq_act_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        if (alarm_mode_e'(mode) == MODE_CMP) begin
            alarm      = cmp_act_q;
            seek_hot   = !cmp_act_q;
            hold_queue = 1'b0;
        end else begin
            alarm      = irq_act_q;
            seek_hot   = irq_seek_hot_q;
            hold_queue = irq_act_q;
        end
    end

    a_r4_cmp_read_ignored: assert property (@(posedge clk) disable iff (rst)
        (!mode && rd && !fire) |=> $stable(cmp_act_q));

    a_r7_read_clears_latch: assert property (@(posedge clk) disable iff (rst)
        (mode && rd && !freeze && !fire) |=> !irq_act_q);

    a_r10_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ($stable(cmp_act_q) && $stable(irq_act_q) && $stable(irq_seek_hot_q)));

    a_r2_rise_needs_fire: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_act_q) |-> $past(fire));

    a_r8_seek_flips_on_latch: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_act_q) |-> (irq_seek_hot_q != $past(irq_seek_hot_q)));
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
    import thermwd_pkg::*;
#(
    parameter int TW = thermwd_pkg::TEMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_done,
    input  logic [TW-1:0] temp_in,
    input  logic [TW-1:0] lim_hot,
    input  logic [TW-1:0] lim_rel,
    input  logic [1:0]    fq_sel,
    input  logic          irq_mode,
    input  logic          shutdown,
    input  logic          pol_high,
    input  logic          reg_rd,
    output logic          alarm_pin
);
    logic       seek_hot;
    logic       trip;
    logic       fire;
    logic       alarm;
    logic       hold_queue;
    conv_eval_t ev;

    thermwd_trip_detect #(.TW(TW)) u_trip (
        .temp     (temp_in),
        .lim_hot  (lim_hot),
        .lim_rel  (lim_rel),
        .seek_hot (seek_hot),
        .trip     (trip)
    );

    always_comb begin
        ev.step = conv_done && !shutdown;
        ev.trip = trip;
    end

    thermwd_fault_queue u_queue (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .hold   (hold_queue),
        .fq_sel (fq_sel),
        .fire   (fire)
    );

    thermwd_alarm_state u_state (
        .clk        (clk),
        .rst        (rst),
        .mode       (irq_mode),
        .fire       (fire),
        .rd         (reg_rd),
        .freeze     (shutdown),
        .alarm      (alarm),
        .seek_hot   (seek_hot),
        .hold_queue (hold_queue)
    );

    always_comb alarm_pin = pol_high ? alarm : !alarm;

    a_r10_pin_frozen: assert property (@(posedge clk) disable iff (rst)
        (shutdown && $stable(pol_high) && $stable(irq_mode)) |=> $stable(alarm_pin));

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (alarm_pin == !pol_high));
endmodule

// File: tb/thermal_alarm_ctrl_test.sv
module thermal_alarm_ctrl_test;
    import thermwd_pkg::*;

    localparam int TW = TEMP_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_done = 1'b0;
    logic [TW-1:0] temp_in = '0;
    logic [TW-1:0] lim_hot = DEF_LIM_HOT;
    logic [TW-1:0] lim_rel = DEF_LIM_REL;
    logic [1:0]    fq_sel = 2'b00;
    logic          irq_mode = 1'b0;
    logic          shutdown = 1'b0;
    logic          pol_high = 1'b0;
    logic          reg_rd = 1'b0;
    logic          alarm_pin;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    thermal_alarm_ctrl #(.TW(TW)) uut (
        .clk (clk), .rst (rst), .conv_done (conv_done), .temp_in (temp_in),
        .lim_hot (lim_hot), .lim_rel (lim_rel), .fq_sel (fq_sel),
        .irq_mode (irq_mode), .shutdown (shutdown), .pol_high (pol_high),
        .reg_rd (reg_rd), .alarm_pin (alarm_pin)
    );

    always #2 clk = !clk;

    // Behavioural reference model
    int m_cmp = 0, m_irq = 0, m_seek_hot = 1, m_run = 0;

    function automatic int run_len(input logic [1:0] c);
        int lens[4] = '{1, 2, 4, 6};
        return lens[c];
    endfunction

    always @(posedge clk) begin
        int t, hot, rel, hit, seek;
        if (rst) begin
            m_cmp = 0; m_irq = 0; m_seek_hot = 1; m_run = 0;
        end else if (!shutdown) begin
            t = $signed(temp_in); hot = $signed(lim_hot); rel = $signed(lim_rel);
            if (!irq_mode) begin
                seek = (m_cmp == 0);
                hit = seek ? (t > hot) : (t < rel);
                if (conv_done) begin
                    if (hit) begin
                        m_run++;
                        if (m_run >= run_len(fq_sel)) begin m_cmp = 1 - m_cmp; m_run = 0; end
                    end else m_run = 0;
                end
            end else if (m_irq == 1) begin
                m_run = 0;
                if (reg_rd) m_irq = 0;
            end else if (conv_done) begin
                hit = m_seek_hot ? (t > hot) : (t < rel);
                if (hit) begin
                    m_run++;
                    if (m_run >= run_len(fq_sel)) begin
                        m_irq = 1; m_seek_hot = 1 - m_seek_hot; m_run = 0;
                    end
                end else m_run = 0;
            end
        end
    end

    function automatic logic model_pin();
        logic a;
        a = irq_mode ? (m_irq != 0) : (m_cmp != 0);
        return pol_high ? a : !a;
    endfunction

    always @(negedge clk) begin
        #1;
        checks++;
        if (alarm_pin !== model_pin()) begin
            errors++;
            $display("FAIL %s model compare at %0t: actual %b expected %b",
                     phase, $time, alarm_pin, model_pin());
        end
    end

    task automatic check_pin(input string req, input logic exp);
        #2;
        checks++;
        if (alarm_pin !== exp) begin
            errors++;
            $display("FAIL %s directed at %0t: actual %b expected %b", req, $time, alarm_pin, exp);
        end
    endtask

    task automatic conv(input int t);
        @(negedge clk);
        conv_done = 1'b1; temp_in = TW'(t);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        phase = "R1"; check_pin("R1", 1'b1);

        // R2/R3: strict comparisons, run of 1
        phase = "R2"; conv(160); check_pin("R2", 1'b1);
        conv(161); check_pin("R2", 1'b0);
        phase = "R3"; conv(150); check_pin("R3", 1'b0);
        conv(149); check_pin("R3", 1'b1);

        // R5 two, R4 reads ignored
        phase = "R5"; fq_sel = 2'b01;
        conv(170); check_pin("R5", 1'b1);
        conv(170); check_pin("R5", 1'b0);
        phase = "R4"; rd(); check_pin("R4", 1'b0);
        rd(); check_pin("R4", 1'b0);

        // R6 miss in mid-run restarts
        phase = "R6"; conv(100); conv(155); conv(100); check_pin("R6", 1'b0);
        conv(100); check_pin("R6", 1'b1);

        // R5 four and six
        phase = "R5"; fq_sel = 2'b10;
        conv(170); conv(170); conv(170); check_pin("R5", 1'b1);
        conv(170); check_pin("R5", 1'b0);
        fq_sel = 2'b11;
        for (int i = 0; i < 5; i++) conv(100);
        check_pin("R5", 1'b0);
        conv(100); check_pin("R5", 1'b1);

        // R10 shutdown in comparator mode
        phase = "R10"; fq_sel = 2'b00; shutdown = 1'b1;
        conv(200); check_pin("R10", 1'b1);
        conv(200); check_pin("R10", 1'b1);
        @(negedge clk); shutdown = 1'b0;
        conv(200); check_pin("R10", 1'b0);

        // R11 polarity
        phase = "R11"; @(negedge clk); pol_high = 1'b1; check_pin("R11", 1'b1);
        @(negedge clk); pol_high = 1'b0; check_pin("R11", 1'b0);

        // R12 signed limits
        phase = "R12"; do_reset();
        lim_hot = TW'(-4); lim_rel = TW'(-20);
        conv(-4); check_pin("R12", 1'b1);
        conv(-3); check_pin("R12", 1'b0);
        conv(-20); check_pin("R12", 1'b0);
        conv(-21); check_pin("R12", 1'b1);
        conv(5); check_pin("R12", 1'b0);

        // R7/R8/R9 interrupt mode
        phase = "R7"; do_reset();
        lim_hot = DEF_LIM_HOT; lim_rel = DEF_LIM_REL; irq_mode = 1'b1;
        check_pin("R7", 1'b1);
        conv(170); check_pin("R7", 1'b0);
        phase = "R9"; conv(100); check_pin("R9", 1'b0);
        phase = "R7"; rd(); check_pin("R7", 1'b1);
        phase = "R8"; conv(170); check_pin("R8", 1'b1);
        conv(140); check_pin("R8", 1'b0);
        rd(); check_pin("R8", 1'b1);
        conv(140); check_pin("R8", 1'b1);
        conv(170); check_pin("R8", 1'b0);

        phase = "R9"; fq_sel = 2'b01;
        conv(100); rd(); conv(100); check_pin("R9", 1'b1);
        conv(100); check_pin("R9", 1'b0);

        phase = "R10"; @(negedge clk); shutdown = 1'b1;
        rd(); check_pin("R10", 1'b0);
        @(negedge clk); shutdown = 1'b0;
        rd(); check_pin("R10", 1'b1);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule